// File: doc/BRIEF.md
# UART Banked Register Access Decoder

This block sits behind the host port of a UART and turns a 3-bit register address with read and write strobes into accesses to a bank of configuration registers. The value held in the line control register selects the bank. With the top bit of that register clear, the normal registers answer. With the top bit set, the two divisor latch bytes take over the two lowest addresses. With the register holding exactly 0xBF, the enhanced feature register and the four flow-control character registers appear instead. The line control register itself stays at address 3 in every bank.

When the divisor bank is active and both divisor bytes are zero, reads of the two lowest addresses return a revision byte, set by a parameter, and a fixed identification byte. Writes still reach the latches. Bit 4 of the enhanced feature register unlocks the upper bits of the interrupt enable, FIFO control and modem control registers. It also unmasks the upper status bits that the block reflects from its status inputs. The block exports every register value, and the enhanced feature fields as separate signals, to the serial engines and flow-control logic around it.

Top module: `uart_bank_decoder`

## Requirements
- R1: Reset sets LCR, IER, FCR, MCR, both divisor bytes, EFR and the four flow-control character registers to 0x00.
- R2: While LCR[7]=1 and LCR is not 0xBF, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. divisor_o is {high, low}.
- R3: In the R2 bank, when both divisor bytes are 0x00, a read of address 0 returns the REVISION parameter (default 0x05) and a read of address 1 returns 0x04. Writes to those addresses still load the latches.
- R4: While LCR equals 0xBF, address 2 reads and writes EFR, and addresses 4, 5, 6 and 7 read and write XON1, XON2, XOFF1 and XOFF2 in that order.
- R5: The EFR fields are exported as follows: bit 7 to auto_cts_o, bit 6 to auto_rts_o, bit 5 to spec_char_o, bit 4 to enh_en_o, and bits 3:0 to swfc_mode_o.
- R6: While EFR[4]=0, writes leave IER[7:4], FCR[5:4] and MCR[7:5] unchanged and load the other bits. While EFR[4]=1, writes load all bits.
- R7: Outside the 0xBF bank, a read of address 2 returns isr_in and a read of address 6 returns msr_in. While EFR[4]=0, bits isr[5:4] and msr[7:4] read as 0.
- R8: Outside the 0xBF bank, address 1 is IER (when LCR[7]=0), address 2 takes FCR writes and address 4 is MCR. Writes in the 0xBF bank to addresses 0 and 1 leave the divisor unchanged.
- R9: rdata is 0x00 while rd_en is low. Reads of unmapped addresses return 0x00: address 0 with LCR[7]=0, addresses 5 and 7 outside the 0xBF bank, and addresses 0 and 1 in the 0xBF bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe, qualifies rdata |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| isr_in | input | 8 | Interrupt status from the interrupt logic |
| msr_in | input | 8 | Modem status from the modem logic |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 16 | Baud divisor {high, low} |
| enh_en_o | output | 1 | Enhanced function enable (EFR[4]) |
| auto_cts_o | output | 1 | Auto-CTS enable |
| auto_rts_o | output | 1 | Auto-RTS enable |
| spec_char_o | output | 1 | Special character detect enable |
| swfc_mode_o | output | 4 | Software flow-control mode |
| xon1_o | output | 8 | XON1 character |
| xon2_o | output | 8 | XON2 character |
| xoff1_o | output | 8 | XOFF1 character |
| xoff2_o | output | 8 | XOFF2 character |

## Verification
The hardest case to reach is a write to a protected register while the enhanced enable is off but the upper bits are already set. Setting those bits needs the enable on, and clearing the enable needs a trip through the 0xBF bank. The stimulus enters the 0xBF bank to set EFR[4], returns to the normal bank to fill IER, goes back to clear EFR[4], then writes zeros. The read-back must show the old upper nibble kept. The ID window is tested twice: once straight after reset, and again once the divisor bytes have been moved away from zero. This shows that the window depends on the latch contents and not on a fixed address.

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder #(
  parameter logic [7:0] REVISION = 8'h05,
  parameter logic [7:0] DEVICE_ID = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  isr_in,
  input  logic [7:0]  msr_in,
  output logic [7:0]  lcr_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  mcr_o,
  output logic [15:0] divisor_o,
  output logic        enh_en_o,
  output logic        auto_cts_o,
  output logic        auto_rts_o,
  output logic        spec_char_o,
  output logic [3:0]  swfc_mode_o,
  output logic [7:0]  xon1_o,
  output logic [7:0]  xon2_o,
  output logic [7:0]  xoff1_o,
  output logic [7:0]  xoff2_o
);

  localparam logic [7:0] BANK_KEY = 8'hBF;

  logic [7:0] lcr, ier, fcr, mcr, dll, dlm, efr;
  logic [7:0] xon1, xon2, xoff1, xoff2;

  logic bank_ext, bank_div, bank_std, id_win, enh;

  assign bank_ext = (lcr == BANK_KEY);
  assign bank_div = lcr[7] && !bank_ext;
  assign bank_std = !lcr[7];
  assign id_win   = bank_div && (dll == 8'h00) && (dlm == 8'h00);
  assign enh      = efr[4];

  logic wr_lcr, wr_ier, wr_fcr, wr_mcr, wr_dll, wr_dlm, wr_efr;
  logic wr_xon1, wr_xon2, wr_xoff1, wr_xoff2;

  assign wr_lcr   = wr_en && addr == 3'd3;
  assign wr_dll   = wr_en && bank_div && addr == 3'd0;
  assign wr_dlm   = wr_en && bank_div && addr == 3'd1;
  assign wr_ier   = wr_en && bank_std && addr == 3'd1;
  assign wr_fcr   = wr_en && !bank_ext && addr == 3'd2;
  assign wr_mcr   = wr_en && !bank_ext && addr == 3'd4;
  assign wr_efr   = wr_en && bank_ext && addr == 3'd2;
  assign wr_xon1  = wr_en && bank_ext && addr == 3'd4;
  assign wr_xon2  = wr_en && bank_ext && addr == 3'd5;
  assign wr_xoff1 = wr_en && bank_ext && addr == 3'd6;
  assign wr_xoff2 = wr_en && bank_ext && addr == 3'd7;

  logic [7:0] ier_nx, fcr_nx, mcr_nx;
  assign ier_nx = enh ? wdata : {ier[7:4], wdata[3:0]};
  assign fcr_nx = enh ? wdata : {wdata[7:6], fcr[5:4], wdata[3:0]};
  assign mcr_nx = enh ? wdata : {mcr[7:5], wdata[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr   <= 8'h00;
      ier   <= 8'h00;
      fcr   <= 8'h00;
      mcr   <= 8'h00;
      dll   <= 8'h00;
      dlm   <= 8'h00;
      efr   <= 8'h00;
      xon1  <= 8'h00;
      xon2  <= 8'h00;
      xoff1 <= 8'h00;
      xoff2 <= 8'h00;
    end else begin
      if (wr_lcr)   lcr   <= wdata;
      if (wr_ier)   ier   <= ier_nx;
      if (wr_fcr)   fcr   <= fcr_nx;
      if (wr_mcr)   mcr   <= mcr_nx;
      if (wr_dll)   dll   <= wdata;
      if (wr_dlm)   dlm   <= wdata;
      if (wr_efr)   efr   <= wdata;
      if (wr_xon1)  xon1  <= wdata;
      if (wr_xon2)  xon2  <= wdata;
      if (wr_xoff1) xoff1 <= wdata;
      if (wr_xoff2) xoff2 <= wdata;
    end
  end

  logic [7:0] isr_vis, msr_vis, rd_mux;
  assign isr_vis = enh ? isr_in : {isr_in[7:6], 2'b00, isr_in[3:0]};
  assign msr_vis = enh ? msr_in : {4'h0, msr_in[3:0]};

  always_comb begin
    rd_mux = 8'h00;
    if (bank_ext) begin
      case (addr)
        3'd2: rd_mux = efr;
        3'd3: rd_mux = lcr;
        3'd4: rd_mux = xon1;
        3'd5: rd_mux = xon2;
        3'd6: rd_mux = xoff1;
        3'd7: rd_mux = xoff2;
        default: rd_mux = 8'h00;
      endcase
    end else begin
      case (addr)
        3'd0: rd_mux = bank_div ? (id_win ? REVISION : dll) : 8'h00;
        3'd1: rd_mux = bank_div ? (id_win ? DEVICE_ID : dlm) : ier;
        3'd2: rd_mux = isr_vis;
        3'd3: rd_mux = lcr;
        3'd4: rd_mux = mcr;
        3'd6: rd_mux = msr_vis;
        default: rd_mux = 8'h00;
      endcase
    end
  end

  assign rdata = rd_en ? rd_mux : 8'h00;

  assign lcr_o       = lcr;
  assign ier_o       = ier;
  assign fcr_o       = fcr;
  assign mcr_o       = mcr;
  assign divisor_o   = {dlm, dll};
  assign enh_en_o    = efr[4];
  assign auto_cts_o  = efr[7];
  assign auto_rts_o  = efr[6];
  assign spec_char_o = efr[5];
  assign swfc_mode_o = efr[3:0];
  assign xon1_o      = xon1;
  assign xon2_o      = xon2;
  assign xoff1_o     = xoff1;
  assign xoff2_o     = xoff2;

endmodule

// File: rtl/uart_bank_decoder_chk.sv
module uart_bank_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  isr_in,
  input logic [7:0]  lcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  mcr_o,
  input logic [15:0] divisor_o,
  input logic        enh_en_o,
  input logic [7:0]  xon1_o
);

  logic in_ext, in_div;
  assign in_ext = (lcr_o == 8'hBF);
  assign in_div = lcr_o[7] && !in_ext;

  AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_div && addr == 3'd1 && divisor_o == 16'h0000) |-> rdata == 8'h04); // R3

  AST_EXT_NO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_ext && addr[2:1] == 2'b00) |=> $stable(divisor_o)); // R8

  AST_XON1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_ext && addr == 3'd4) |=> xon1_o == $past(wdata)); // R4

  AST_IER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lcr_o[7] && addr == 3'd1 && !enh_en_o) |=> ier_o[7:4] == $past(ier_o[7:4])); // R6

  AST_MCR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ext && addr == 3'd4 && !enh_en_o) |=> mcr_o[7:5] == $past(mcr_o[7:5])); // R6

  AST_ISR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_ext && addr == 3'd2 && !enh_en_o) |-> (rdata[5:4] == 2'b00 && rdata[3:0] == isr_in[3:0])); // R7

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00); // R9

endmodule

bind uart_bank_decoder uart_bank_decoder_chk chk_i (.*);

// File: tb/uart_bank_decoder_tb_top.sv
module uart_bank_decoder_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata, rdata, isr_in, msr_in;
  logic [7:0]  lcr_o, ier_o, fcr_o, mcr_o;
  logic [15:0] divisor_o;
  logic        enh_en_o, auto_cts_o, auto_rts_o, spec_char_o;
  logic [3:0]  swfc_mode_o;
  logic [7:0]  xon1_o, xon2_o, xoff1_o, xoff2_o;

  uart_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .isr_in(isr_in), .msr_in(msr_in),
    .lcr_o(lcr_o), .ier_o(ier_o), .fcr_o(fcr_o), .mcr_o(mcr_o),
    .divisor_o(divisor_o), .enh_en_o(enh_en_o), .auto_cts_o(auto_cts_o),
    .auto_rts_o(auto_rts_o), .spec_char_o(spec_char_o), .swfc_mode_o(swfc_mode_o),
    .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    check(tag, {24'h0, rdata}, {24'h0, exp});
    rd_en = 1'b0;
  endtask

  // {op(1=read), addr, data/expected, requirement number}
  localparam int NV = 40;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h80, 4'd2},
    {1'b1, 3'd0, 8'h05, 4'd3},   // R3 revision
    {1'b1, 3'd1, 8'h04, 4'd3},   // R3 id
    {1'b0, 3'd0, 8'h34, 4'd2},
    {1'b1, 3'd0, 8'h34, 4'd2},   // R2
    {1'b1, 3'd1, 8'h00, 4'd2},   // R2 window closed
    {1'b0, 3'd1, 8'h12, 4'd2},
    {1'b1, 3'd1, 8'h12, 4'd2},
    {1'b0, 3'd3, 8'hBF, 4'd4},
    {1'b0, 3'd2, 8'hD5, 4'd4},
    {1'b1, 3'd2, 8'hD5, 4'd4},   // R4 EFR
    {1'b0, 3'd4, 8'h11, 4'd4},
    {1'b0, 3'd5, 8'h13, 4'd4},
    {1'b0, 3'd6, 8'h91, 4'd4},
    {1'b0, 3'd7, 8'h93, 4'd4},
    {1'b1, 3'd4, 8'h11, 4'd4},
    {1'b1, 3'd5, 8'h13, 4'd4},
    {1'b1, 3'd6, 8'h91, 4'd4},
    {1'b1, 3'd7, 8'h93, 4'd4},
    {1'b1, 3'd0, 8'h00, 4'd9},   // R9 unmapped in 0xBF bank
    {1'b0, 3'd0, 8'hFF, 4'd8},
    {1'b0, 3'd1, 8'hFF, 4'd8},
    {1'b0, 3'd3, 8'h80, 4'd8},
    {1'b1, 3'd0, 8'h34, 4'd8},   // R8 divisor kept
    {1'b1, 3'd1, 8'h12, 4'd8},
    {1'b0, 3'd3, 8'h03, 4'd8},
    {1'b0, 3'd1, 8'hFF, 4'd6},
    {1'b1, 3'd1, 8'hFF, 4'd6},   // R6 unlocked
    {1'b1, 3'd2, 8'hFF, 4'd7},   // R7 unmasked
    {1'b1, 3'd6, 8'hFF, 4'd7},
    {1'b1, 3'd5, 8'h00, 4'd9},   // R9
    {1'b1, 3'd0, 8'h00, 4'd9},
    {1'b0, 3'd3, 8'hBF, 4'd6},
    {1'b0, 3'd2, 8'h05, 4'd6},
    {1'b0, 3'd3, 8'h03, 4'd6},
    {1'b0, 3'd1, 8'h00, 4'd6},
    {1'b1, 3'd1, 8'hF0, 4'd6},   // R6 locked nibble kept
    {1'b1, 3'd2, 8'hCF, 4'd7},   // R7 masked
    {1'b1, 3'd6, 8'h0F, 4'd7},
    {1'b1, 3'd3, 8'h03, 4'd8}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 3'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    isr_in = 8'hFF; msr_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 lcr", {24'h0, lcr_o}, 32'h0);
    check("R1 ier/fcr/mcr", {8'h0, ier_o, fcr_o, mcr_o}, 32'h0);
    check("R1 divisor", {16'h0, divisor_o}, 32'h0);
    check("R1 flow chars", {xon1_o, xon2_o, xoff1_o, xoff2_o}, 32'h0);
    check("R1 efr", {24'h0, enh_en_o, auto_cts_o, auto_rts_o, spec_char_o, swfc_mode_o}, 32'h0);
    // R9 idle bus
    check("R9 idle rdata", {24'h0, rdata}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) rd(VEC[i][14:12], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else wr(VEC[i][14:12], VEC[i][11:4]);
      if (i == 10) begin
        @(negedge clk);
        // R5 EFR = 0xD5
        check("R5 fields", {26'h0, auto_cts_o, auto_rts_o, spec_char_o, enh_en_o, swfc_mode_o[1:0]},
              {26'h0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01});
        check("R5 swfc", {28'h0, swfc_mode_o}, 32'h5);
      end
    end

    // R6 FCR and MCR lock with EFR[4]=0
    wr(3'd2, 8'hFF);
    check("R6 fcr locked", {24'h0, fcr_o}, 32'hCF);
    wr(3'd4, 8'hFF);
    check("R6 mcr locked", {24'h0, mcr_o}, 32'h1F);
    rd(3'd4, 8'h1F, "R8 mcr read");
    check("R5 fields off", {27'h0, enh_en_o, swfc_mode_o}, 32'h05);
    check("R2 divisor_o", {16'h0, divisor_o}, 32'h1234);

    // reset again, ID window reopens
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 after reset", {lcr_o, ier_o, fcr_o, mcr_o}, 32'h0);
    check("R1 xon after reset", {xon1_o, xon2_o, xoff1_o, xoff2_o}, 32'h0);
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h05, "R3 revision again");
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    check("R3 write through window", {16'h0, divisor_o}, 32'h0001);
    rd(3'd0, 8'h01, "R2 window closed");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule